// File: doc/BRIEF.md
# Serial Framed Packet Receiver

This block sits on one output lane of a bit-serial router. The lane has three wires: a data bit, an active-low frame line and an active-low valid line. The block accepts a data bit in any clock cycle where both control lines are low. It packs the accepted bits into bytes, least significant bit first, and puts out each finished byte with a one-cycle strobe.

Packet boundaries come only from the frame line. No length field is used. A falling edge of the frame line opens a packet. A rising edge starts the closing of the packet, and the packet is confirmed closed once the line has stayed high for `CLOSE_CYC` cycles in a row. On close, the block pulses a done signal and reports the number of whole bytes and whether unfinished bits were left over. If the frame line falls again before the close is confirmed, the open packet is reported as aborted and a new packet starts in that same cycle.

To cover several lanes, place one instance on each lane. Each output is registered and changes one clock edge after the input cycle that causes it.

Top module: `serial_pkt_rx`

## Requirements
- R1: A bit is accepted only in a cycle where `lane_frame_n` and `lane_valid_n` are both low. Data in any other cycle adds nothing to the byte being assembled.
- R2: Bits are packed least significant bit first. The first accepted bit of a packet lands in `byte_data[0]`. When the eighth bit is accepted, `byte_stb` is high for exactly one cycle after that clock edge, and `byte_data` holds the finished byte in that cycle.
- R3: A cycle inside a packet with frame low and valid high is skipped. The partial byte and the bit position are left unchanged.
- R4: A falling edge of `lane_frame_n` opens a packet. While no packet is open, the lane data is ignored even when valid is low.
- R5: A packet closes after `lane_frame_n` has been high for `CLOSE_CYC` consecutive cycles (default 2). After the edge of the last of those cycles, `pkt_done` pulses for one cycle, `pkt_bytes` gives the number of whole bytes and `pkt_abort` is 0.
- R6: `pkt_partial` is 1 at close when 1 to 7 accepted bits were left over after the last whole byte. It is 0 when the accepted bit count is a multiple of 8, and that includes zero.
- R7: A falling edge of `lane_frame_n` after fewer than `CLOSE_CYC` high cycles closes the open packet with `pkt_done` and `pkt_abort` both 1, along with its byte count and partial flag. A new packet starts in that same cycle and can accept that cycle's bit.
- R8: An active-low reset clears every output, the byte count, the bit index and the in-packet state. A packet interrupted by reset is never reported.
- R9: Packet length is unrestricted. Empty packets are supported, and so are packets whose lengths are not multiples of 8 and packets of many bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_bit | input | 1 | Serial data bit |
| lane_frame_n | input | 1 | Active-low packet frame |
| lane_valid_n | input | 1 | Active-low bit qualifier |
| byte_data | output | DATA_W | Last assembled byte |
| byte_stb | output | 1 | One-cycle pulse: byte_data is new |
| pkt_done | output | 1 | One-cycle pulse: packet closed |
| pkt_bytes | output | CNT_W | Whole bytes in the closed packet |
| pkt_partial | output | 1 | Leftover bits existed at close |
| pkt_abort | output | 1 | Packet closed by a new frame fall |

## Verification
A wrong bit index shows up at the ports within eight accepted bits. The strobe lands one bit early or late, and every later byte of the packet compares wrong. A wrong in-packet state shows up at the next frame edge: as a strobe from ignored idle data, a missing done pulse, or a false abort flag. A wrong byte count or partial flag shows only at the close of the packet, so the tests use packets of many different lengths and skip patterns to bring each one out.

// File: rtl/serial_pkt_rx_pkg.sv
package serial_pkt_rx_pkg;

    typedef struct packed {
        logic done;
        logic partial;
        logic abort;
    } close_flags_t;

    localparam int unsigned DEF_DATA_W    = 8;
    localparam int unsigned DEF_CNT_W     = 16;
    localparam int unsigned DEF_CLOSE_CYC = 2;

endpackage

// File: rtl/serial_pkt_rx_frame.sv
module serial_pkt_rx_frame #(
    parameter int unsigned CLOSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n_i,
    input  logic valid_n_i,
    output logic open_o,
    output logic close_o,
    output logic abort_o,
    output logic accept_o
);
    localparam int unsigned RUN_W = (CLOSE_CYC > 2) ? $clog2(CLOSE_CYC) : 1;

    typedef struct packed {
        logic             prev;
        logic             inpkt;
        logic [RUN_W-1:0] run;
    } trk_t;

    trk_t trk_d, trk_q;
    logic fall;

    always_comb begin
        trk_d    = trk_q;
        fall     = !frame_n_i && trk_q.prev;
        open_o   = 1'b0;
        close_o  = 1'b0;
        abort_o  = 1'b0;
        trk_d.prev = frame_n_i;
        if (trk_q.inpkt) begin
            if (frame_n_i) begin
                if (trk_q.run == RUN_W'(CLOSE_CYC - 1)) begin
                    close_o     = 1'b1;
                    trk_d.inpkt = 1'b0;
                    trk_d.run   = '0;
                end else begin
                    trk_d.run = trk_q.run + 1'b1;
                end
            end else begin
                trk_d.run = '0;
                if (fall) begin
                    close_o = 1'b1;
                    abort_o = 1'b1;
                    open_o  = 1'b1;
                end
            end
        end else if (fall) begin
            open_o      = 1'b1;
            trk_d.inpkt = 1'b1;
            trk_d.run   = '0;
        end
        accept_o = !frame_n_i && !valid_n_i && (trk_q.inpkt || fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{prev: 1'b1, inpkt: 1'b0, run: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    // R4: a frame fall always opens a packet
    p_fall_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n_i && $past(frame_n_i)) |-> open_o);

    // R7: an abort can only happen while the frame line is low
    p_abort_frame_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !frame_n_i);

endmodule

// File: rtl/serial_pkt_rx_asm.sv
module serial_pkt_rx_asm #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              accept_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              stb_o,
    output logic              partial_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int unsigned IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              stb;
    } asm_t;

    asm_t asm_d, asm_q;
    logic [DATA_W-1:0] base_sh, next_sh;
    logic [IDX_W-1:0]  base_idx;
    logic [CNT_W-1:0]  base_cnt;

    always_comb begin
        asm_d     = asm_q;
        asm_d.stb = 1'b0;
        base_sh   = clear_i ? '0 : asm_q.shreg;
        base_idx  = clear_i ? '0 : asm_q.idx;
        base_cnt  = clear_i ? '0 : asm_q.cnt;
        next_sh   = {bit_i, base_sh[DATA_W-1:1]};
        asm_d.shreg = base_sh;
        asm_d.idx   = base_idx;
        asm_d.cnt   = base_cnt;
        if (accept_i) begin
            asm_d.shreg = next_sh;
            if (base_idx == LAST_IDX) begin
                asm_d.idx  = '0;
                asm_d.data = next_sh;
                asm_d.stb  = 1'b1;
                asm_d.cnt  = (base_cnt == CNT_MAX) ? base_cnt : base_cnt + 1'b1;
            end else begin
                asm_d.idx = base_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign data_o    = asm_q.data;
    assign stb_o     = asm_q.stb;
    assign partial_o = (asm_q.idx != '0);
    assign cnt_o     = asm_q.cnt;

    // R2: two strobes are never adjacent, a byte needs several accepted bits
    p_stb_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);

    // R3: a cycle without accept leaves the partial position untouched
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !clear_i) |=> $stable(asm_q.idx));

endmodule

// File: rtl/serial_pkt_rx.sv
module serial_pkt_rx #(
    parameter int unsigned DATA_W    = serial_pkt_rx_pkg::DEF_DATA_W,
    parameter int unsigned CNT_W     = serial_pkt_rx_pkg::DEF_CNT_W,
    parameter int unsigned CLOSE_CYC = serial_pkt_rx_pkg::DEF_CLOSE_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_bit,
    input  logic              lane_frame_n,
    input  logic              lane_valid_n,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_stb,
    output logic              pkt_done,
    output logic [CNT_W-1:0]  pkt_bytes,
    output logic              pkt_partial,
    output logic              pkt_abort
);
    import serial_pkt_rx_pkg::*;

    typedef struct packed {
        close_flags_t     flags;
        logic [CNT_W-1:0] bytes;
    } rpt_t;

    logic open_w, close_w, abort_w, accept_w;
    logic partial_w;
    logic [CNT_W-1:0] cnt_w;
    rpt_t rpt_d, rpt_q;

    serial_pkt_rx_frame #(
        .CLOSE_CYC (CLOSE_CYC)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n_i (lane_frame_n),
        .valid_n_i (lane_valid_n),
        .open_o    (open_w),
        .close_o   (close_w),
        .abort_o   (abort_w),
        .accept_o  (accept_w)
    );

    serial_pkt_rx_asm #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (open_w || close_w),
        .accept_i  (accept_w),
        .bit_i     (lane_bit),
        .data_o    (byte_data),
        .stb_o     (byte_stb),
        .partial_o (partial_w),
        .cnt_o     (cnt_w)
    );

    always_comb begin
        rpt_d            = rpt_q;
        rpt_d.flags.done = 1'b0;
        if (close_w) begin
            rpt_d.flags.done    = 1'b1;
            rpt_d.flags.partial = partial_w;
            rpt_d.flags.abort   = abort_w;
            rpt_d.bytes         = cnt_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_q <= '0;
        end else begin
            rpt_q <= rpt_d;
        end
    end

    assign pkt_done    = rpt_q.flags.done;
    assign pkt_partial = rpt_q.flags.partial;
    assign pkt_abort   = rpt_q.flags.abort;
    assign pkt_bytes   = rpt_q.bytes;

    // R1: a frame-high cycle never yields a byte
    p_frame_high_no_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lane_frame_n |=> !byte_stb);

    // R3: a valid-high cycle never yields a byte
    p_valid_high_no_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid_n |=> !byte_stb);

    // R5: the done pulse lasts a single cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R7: an abort is reported only with a done pulse, on a low frame line
    p_abort_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_abort) |-> (pkt_done && !$past(lane_frame_n)));

endmodule

// File: tb/serial_pkt_rx_test.sv
`timescale 1ns/1ps
module serial_pkt_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lane_bit = 1'b0;
    logic lane_frame_n = 1'b1;
    logic lane_valid_n = 1'b1;
    logic [7:0]  byte_data;
    logic        byte_stb;
    logic        pkt_done;
    logic [15:0] pkt_bytes;
    logic        pkt_partial;
    logic        pkt_abort;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0]  exp_bytes[$];
    logic [17:0] exp_ends[$];

    always #2 clk = ~clk;

    serial_pkt_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_bit     (lane_bit),
        .lane_frame_n (lane_frame_n),
        .lane_valid_n (lane_valid_n),
        .byte_data    (byte_data),
        .byte_stb     (byte_stb),
        .pkt_done     (pkt_done),
        .pkt_bytes    (pkt_bytes),
        .pkt_partial  (pkt_partial),
        .pkt_abort    (pkt_abort)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic v, input logic d);
        @(negedge clk);
        lane_frame_n = f;
        lane_valid_n = v;
        lane_bit     = d;
    endtask

    // Push expected results, then drive the packet and its trailing high cycles
    task automatic send_pkt(input int nbits, input logic [63:0] pay, input int skip_every, input int tail_hi);
        for (int k = 0; k < nbits / 8; k++) exp_bytes.push_back(pay[8*k +: 8]);
        exp_ends.push_back({tail_hi < 2, (nbits % 8) != 0, 16'(nbits / 8)});
        for (int i = 0; i < nbits; i++) begin
            if (skip_every != 0 && (i % skip_every) == skip_every - 1)
                drive(1'b0, 1'b1, ~pay[i]);
            drive(1'b0, 1'b0, pay[i]);
        end
        if (nbits == 0) drive(1'b0, 1'b1, 1'b1);
        for (int t = 0; t < tail_hi; t++) drive(1'b1, 1'b0, 1'b1);
    endtask

    task automatic check_reset_state(input string req);
        check(byte_data == 8'h00, req, byte_data, 0);
        check(byte_stb == 1'b0, req, byte_stb, 0);
        check(pkt_done == 1'b0, req, pkt_done, 0);
        check(pkt_bytes == 16'h0, req, pkt_bytes, 0);
        check({pkt_partial, pkt_abort} == 2'b00, req, {pkt_partial, pkt_abort}, 0);
    endtask

    // Monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_stb) begin
                if (exp_bytes.size() == 0) check(1'b0, "R1 R4 unexpected byte", byte_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_bytes.pop_front();
                    check(byte_data == e, "R2 R3 R9 byte", byte_data, e);
                end
            end
            if (pkt_done) begin
                if (exp_ends.size() == 0) check(1'b0, "R5 R7 unexpected done", pkt_bytes, 0);
                else begin
                    logic [17:0] e;
                    e = exp_ends.pop_front();
                    check({pkt_abort, pkt_partial, pkt_bytes} == e, "R5 R6 R7 close",
                          {pkt_abort, pkt_partial, pkt_bytes}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R8 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1 R4: idle noise with valid low while frame high
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b1);
        send_pkt(24, 64'h1E_C3A5, 0, 2);          // R2 R5
        send_pkt(21, 64'h15_B7E9, 3, 3);          // R3 R6
        send_pkt(0, 64'h0, 0, 2);                 // R6 R9 empty
        send_pkt(20, 64'hA_5F3C, 0, 1);           // R7 abort
        send_pkt(16, 64'h9D_62, 5, 2);
        send_pkt(40, 64'h87_6543_21F0, 0, 4);     // R9 long
        // R8: reset in the middle of a packet
        exp_bytes.push_back(8'h4B);
        for (int i = 0; i < 13; i++) drive(1'b0, 1'b0, (i < 8) ? 1'((8'h4B >> i) & 1) : 1'b1);
        @(negedge clk);
        lane_frame_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R8 mid-packet reset");
        @(negedge clk);
        rst_n = 1'b1;
        send_pkt(8, 64'hC6, 0, 2);                // R8 counts restart from zero
        repeat (6) drive(1'b1, 1'b1, 1'b0);
        check(exp_bytes.size() == 0, "R2 missing bytes", exp_bytes.size(), 0);
        check(exp_ends.size() == 0, "R5 missing done", exp_ends.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule